// File: doc/BRIEF.md
# Alarm-Triggered Power-Enable Sequencer

This block owns the enable line of an external power-management chip. Software programs a dedicated shutdown alarm (six BCD time fields) and a power-control word. When the running BCD time from the calendar first becomes equal to the shutdown alarm, a sticky alarm flag is raised. If power control is enabled at that moment, the enable line drops and the system loses power.

Power comes back through either of two paths. The first is any of four external wakeup pins that is enabled and sits at its programmed active level after synchronisation. The second is the main calendar alarm, provided its interrupt enable is set. Bringing power back clears neither the sticky flag nor any configuration. Software must clear the flag with a write-one-to-clear before the alarm can cause another shutdown.

The register port is a plain single-cycle write strobe with a combinational read-back selected by the address. It has no back-pressure, because no data stream passes through the block. Every write completes on the clock edge at which it is presented.

Top module: `alarm_pwr_seq`

## Requirements
- R1: After reset `pwr_en_o` is 1, `alarm2_irq_o` is 0, and every register reads 0.
- R2: Shutdown alarm fields are 8-bit BCD at byte offsets 0x80 (seconds), 0x84 (minutes), 0x88 (hours), 0x8C (days), 0x90 (months) and 0x94 (years). The power word is at 0x98: bits 3:0 are wake enables, bits 7:4 are wake polarities, and bit 16 is the power-control enable. Other bits read 0. The interrupt-enable register is at 0x48, with bit 3 for the main alarm and bit 4 for the shutdown alarm. The status register is at 0x44, with bit 7 as the shutdown flag. Unmapped offsets read 0.
- R3: `now_bcd_i` carries seconds in [7:0], minutes in [15:8], hours in [23:16], days in [31:24], months in [39:32] and years in [47:40]. When all six fields equal the alarm and were not all equal in the previous cycle, status bit 7 is set after that clock edge. An equality already present when reset is released does not count.
- R4: Writing 1 to status bit 7 clears the flag. Writing 0 leaves it unchanged. A new match in the same cycle as the clearing write wins, and the flag stays set.
- R5: A match that finds the flag clear while power word bit 16 is set drives `pwr_en_o` to 0 after the same edge that sets the flag.
- R6: `pwr_en_o` is 0 only while power word bit 16 is set. A match with bit 16 clear sets the flag but leaves power on. Clearing bit 16 while shut down restores power at the next edge.
- R7: While shut down, wake pin i restores power when enable bit i is set and its level, after a two-flop synchroniser, equals 1 with polarity bit 4+i clear or equals 0 with polarity bit 4+i set. Power returns after the third clock edge following the pin change. A disabled pin, or a pin at its inactive level, has no effect.
- R8: While shut down, `main_alarm_i` high restores power at the next edge if interrupt-enable bit 3 is set. It has no effect when that bit is clear.
- R9: Restoring power leaves the flag set. A match while the flag is set does not shut down. After the flag is cleared, the next match shuts down again.
- R10: `alarm2_irq_o` equals the shutdown flag gated by interrupt-enable bit 4.
- R11: When a shutdown match and an active wake source occur in the same cycle, the shutdown takes effect. The still-active wake source then restores power one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| now_bcd_i | input | 48 | Current BCD time from the calendar |
| main_alarm_i | input | 1 | Main calendar alarm indication |
| wake_pins_i | input | 4 | Asynchronous external wakeup pins |
| pwr_en_o | output | 1 | Power enable to the external power chip, 1 = on |
| alarm2_irq_o | output | 1 | Shutdown-alarm interrupt |

## Verification
The bench builds the block with its defaults: four wake pins and a two-stage synchroniser. With these values every pin's enable and polarity field is reachable, and the wake latency of exactly three edges can be checked at a fixed cycle. The bench drives the time input directly, so each match edge is placed in the cycle under test. This lets it reach the corner orderings: a clearing write against a new match, and a shutdown against a wake source that is already active.

// File: rtl/pmseq_pkg.sv
package pmseq_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 6;
  localparam int TIME_W     = FIELD_W * NUM_FIELDS;

  localparam int OFF_ALARM_BASE = 'h80;
  localparam int OFF_ALARM_STEP = 4;
  localparam int OFF_PWR_WORD   = 'h98;
  localparam int OFF_STATUS     = 'h44;
  localparam int OFF_IRQ_EN     = 'h48;

  localparam int BIT_PWR_CTRL   = 16;
  localparam int BIT_POL_LSB    = 4;
  localparam int BIT_FLAG       = 7;
  localparam int BIT_IEN_MAIN   = 3;
  localparam int BIT_IEN_ALARM2 = 4;
endpackage

// File: rtl/pmseq_regs.sv
module pmseq_regs
  import pmseq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int WAKE_N = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              set_flag_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [TIME_W-1:0] alarm_o,
  output logic              ctrl_en_o,
  output logic [WAKE_N-1:0] wake_en_o,
  output logic [WAKE_N-1:0] wake_pol_o,
  output logic              ien_main_o,
  output logic              ien_alarm2_o,
  output logic              flag_o
);
  localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(OFF_PWR_WORD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFF_IRQ_EN);

  logic [TIME_W-1:0] alarm_q;
  logic              ctrl_q, ien_main_q, ien_alm2_q, flag_q;
  logic [WAKE_N-1:0] en_q, pol_q;
  logic              clr_req;

  wire unused_wdata = ^wdata_i;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam logic [ADDR_W-1:0] A_FLD = ADDR_W'(OFF_ALARM_BASE + OFF_ALARM_STEP * g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          alarm_q[g*FIELD_W +: FIELD_W] <= '0;
      else if (wr_i && addr_i == A_FLD)     alarm_q[g*FIELD_W +: FIELD_W] <= wdata_i[FIELD_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 1'b0;
      en_q   <= '0;
      pol_q  <= '0;
    end else if (wr_i && addr_i == A_PWR) begin
      ctrl_q <= wdata_i[BIT_PWR_CTRL];
      en_q   <= wdata_i[WAKE_N-1:0];
      pol_q  <= wdata_i[BIT_POL_LSB +: WAKE_N];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_main_q <= 1'b0;
      ien_alm2_q <= 1'b0;
    end else if (wr_i && addr_i == A_IEN) begin
      ien_main_q <= wdata_i[BIT_IEN_MAIN];
      ien_alm2_q <= wdata_i[BIT_IEN_ALARM2];
    end
  end

  assign clr_req = wr_i && (addr_i == A_STAT) && wdata_i[BIT_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (set_flag_i) flag_q <= 1'b1;
    else if (clr_req)    flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (addr_i == ADDR_W'(OFF_ALARM_BASE + OFF_ALARM_STEP * i))
        rdata_o[FIELD_W-1:0] = alarm_q[i*FIELD_W +: FIELD_W];
    end
    if (addr_i == A_PWR) begin
      rdata_o[BIT_PWR_CTRL]            = ctrl_q;
      rdata_o[WAKE_N-1:0]              = en_q;
      rdata_o[BIT_POL_LSB +: WAKE_N]   = pol_q;
    end
    if (addr_i == A_STAT) rdata_o[BIT_FLAG] = flag_q;
    if (addr_i == A_IEN) begin
      rdata_o[BIT_IEN_MAIN]   = ien_main_q;
      rdata_o[BIT_IEN_ALARM2] = ien_alm2_q;
    end
  end

  assign alarm_o      = alarm_q;
  assign ctrl_en_o    = ctrl_q;
  assign wake_en_o    = en_q;
  assign wake_pol_o   = pol_q;
  assign ien_main_o   = ien_main_q;
  assign ien_alarm2_o = ien_alm2_q;
  assign flag_o       = flag_q;

  // R3
  flag_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_flag_i |=> flag_o);

  // R4
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req && !set_flag_i) |=> !flag_o);
endmodule

// File: rtl/pmseq_match.sv
module pmseq_match
  import pmseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] now_i,
  input  logic [TIME_W-1:0] alarm_i,
  output logic              match_o
);
  logic [NUM_FIELDS-1:0] fld_eq;
  logic                  eq_all, eq_q;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    assign fld_eq[g] = (now_i[g*FIELD_W +: FIELD_W] == alarm_i[g*FIELD_W +: FIELD_W]);
  end

  assign eq_all = &fld_eq;

  // Resetting to 1 masks an equality already present out of reset.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b1;
    else         eq_q <= eq_all;
  end

  assign match_o = eq_all & ~eq_q;

  // R3
  one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);
endmodule

// File: rtl/pmseq_wake.sv
module pmseq_wake #(
  parameter int WAKE_N      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WAKE_N-1:0] pins_i,
  input  logic [WAKE_N-1:0] en_i,
  input  logic [WAKE_N-1:0] pol_i,
  output logic              wake_o
);
  logic [WAKE_N-1:0] sync_q [SYNC_STAGES];
  logic [WAKE_N-1:0] active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '0;
    end else begin
      sync_q[0] <= pins_i;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
    end
  end

  // Polarity 1 selects an active-low pin.
  for (genvar g = 0; g < WAKE_N; g++) begin : g_pin
    assign active[g] = en_i[g] & (sync_q[SYNC_STAGES-1][g] ^ pol_i[g]);
  end

  assign wake_o = |active;
endmodule

// File: rtl/alarm_pwr_seq.sv
module alarm_pwr_seq
  import pmseq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int WAKE_N      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [TIME_W-1:0] now_bcd_i,
  input  logic              main_alarm_i,
  input  logic [WAKE_N-1:0] wake_pins_i,
  output logic              pwr_en_o,
  output logic              alarm2_irq_o
);
  logic [TIME_W-1:0] alarm;
  logic              ctrl_en, ien_main, ien_alm2, flag;
  logic [WAKE_N-1:0] wk_en, wk_pol;
  logic              match, wake_any, main_wake, set_off, off_q;

  pmseq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAKE_N(WAKE_N)) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .set_flag_i  (match),
    .rdata_o     (reg_rdata_o),
    .alarm_o     (alarm),
    .ctrl_en_o   (ctrl_en),
    .wake_en_o   (wk_en),
    .wake_pol_o  (wk_pol),
    .ien_main_o  (ien_main),
    .ien_alarm2_o(ien_alm2),
    .flag_o      (flag)
  );

  pmseq_match match_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .now_i  (now_bcd_i),
    .alarm_i(alarm),
    .match_o(match)
  );

  pmseq_wake #(.WAKE_N(WAKE_N), .SYNC_STAGES(SYNC_STAGES)) wake_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pins_i(wake_pins_i),
    .en_i  (wk_en),
    .pol_i (wk_pol),
    .wake_o(wake_any)
  );

  assign main_wake = main_alarm_i & ien_main;
  assign set_off   = match & ~flag & ctrl_en;

  // Shutdown wins over a coincident wake source.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    off_q <= 1'b0;
    else if (set_off)               off_q <= 1'b1;
    else if (wake_any || main_wake) off_q <= 1'b0;
  end

  assign pwr_en_o     = ~(off_q & ctrl_en);
  assign alarm2_irq_o = flag & ien_alm2;

  // R5
  shutdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !flag && ctrl_en) |=> !pwr_en_o);

  // R7 R8 R6
  wake_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_en_o) |-> ($past(wake_any) || $past(main_wake) || !ctrl_en));

  // R9
  no_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && flag && pwr_en_o && !($fell(ctrl_en))) |=> pwr_en_o || !$past(pwr_en_o, 1) || $past(off_q));
endmodule

// File: tb/alarm_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module alarm_pwr_seq_tb_top;
  localparam logic [47:0] ALM  = {8'h24, 8'h06, 8'h15, 8'h12, 8'h30, 8'h59};
  localparam logic [47:0] AWAY = {8'h24, 8'h06, 8'h15, 8'h12, 8'h30, 8'h58};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [47:0] now_bcd = '0;
  logic        main_alarm = 1'b0;
  logic [3:0]  wake_pins = 4'b1111;
  logic        pwr_en, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_tag = "R1";

  always #2 clk = ~clk;

  alarm_pwr_seq dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .now_bcd_i   (now_bcd),
    .main_alarm_i(main_alarm),
    .wake_pins_i (wake_pins),
    .pwr_en_o    (pwr_en),
    .alarm2_irq_o(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference state
  logic [47:0] m_alm;
  logic [31:0] m_pwr;
  logic [7:0]  m_ien;
  logic        m_flag, m_off, m_prev_eq;
  logic [3:0]  m_s1, m_s2;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h80: return {24'h0, m_alm[7:0]};
      8'h84: return {24'h0, m_alm[15:8]};
      8'h88: return {24'h0, m_alm[23:16]};
      8'h8C: return {24'h0, m_alm[31:24]};
      8'h90: return {24'h0, m_alm[39:32]};
      8'h94: return {24'h0, m_alm[47:40]};
      8'h98: return m_pwr;
      8'h44: return {24'h0, m_flag, 7'h0};
      8'h48: return {24'h0, m_ien};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_alm = '0; m_pwr = '0; m_ien = '0; m_flag = 0; m_off = 0;
      m_prev_eq = 1; m_s1 = '0; m_s2 = '0;
    end else begin
      bit eq, hit, wk, mw, down, clr;
      eq   = (now_bcd == m_alm);
      hit  = eq && !m_prev_eq;
      wk   = |(m_pwr[3:0] & (m_s2 ^ m_pwr[7:4]));
      mw   = main_alarm && m_ien[3];
      down = hit && !m_flag && m_pwr[16];
      clr  = reg_wr && reg_addr == 8'h44 && reg_wdata[7];
      if (hit) m_flag = 1; else if (clr) m_flag = 0;
      if (down) m_off = 1; else if (wk || mw) m_off = 0;
      m_prev_eq = eq;
      m_s2 = m_s1;
      m_s1 = wake_pins;
      if (reg_wr) begin
        case (reg_addr)
          8'h80: m_alm[7:0]   = reg_wdata[7:0];
          8'h84: m_alm[15:8]  = reg_wdata[7:0];
          8'h88: m_alm[23:16] = reg_wdata[7:0];
          8'h8C: m_alm[31:24] = reg_wdata[7:0];
          8'h90: m_alm[39:32] = reg_wdata[7:0];
          8'h94: m_alm[47:40] = reg_wdata[7:0];
          8'h98: m_pwr = reg_wdata & 32'h0001_00FF;
          8'h48: m_ien = reg_wdata[7:0] & 8'h18;
          default: ;
        endcase
      end
    end
    #1;
    chk({31'h0, pwr_en}, {31'h0, !(m_off && m_pwr[16])}, {cur_tag, " pwr_en per-cycle"});
    chk({31'h0, irq}, {31'h0, m_flag && m_ien[4]}, {cur_tag, " R10 irq per-cycle"});
    chk(reg_rdata, m_read(reg_addr), {cur_tag, " rdata per-cycle"});
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #0.5;
    chk(reg_rdata, exp, tag);
  endtask

  task automatic hit_alarm();
    now_bcd = AWAY; tick(1);
    now_bcd = ALM;  tick(1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    cur_tag = "R1";
    chk({31'h0, pwr_en}, 32'h1, "R1 pwr_en after reset");
    chk({31'h0, irq}, 32'h0, "R1 irq after reset");
    rd_chk(8'h44, 32'h0, "R1 status after reset");
    rd_chk(8'h98, 32'h0, "R1 power word after reset");
    rd_chk(8'h80, 32'h0, "R1 alarm seconds after reset");

    cur_tag = "R2";
    wr(8'h80, 32'h59); wr(8'h84, 32'h30); wr(8'h88, 32'h12);
    wr(8'h8C, 32'h15); wr(8'h90, 32'h06); wr(8'h94, 32'hFFFF_FF24);
    rd_chk(8'h88, 32'h12, "R2 alarm hours readback");
    rd_chk(8'h94, 32'h24, "R2 alarm years readback");
    wr(8'h98, 32'hFFFF_FFFF);
    rd_chk(8'h98, 32'h0001_00FF, "R2 power word mask");
    wr(8'h48, 32'hFF);
    rd_chk(8'h48, 32'h18, "R2 irq enable mask");
    rd_chk(8'h50, 32'h0, "R2 unmapped offset");
    wr(8'h98, 32'h0001_0000);

    cur_tag = "R5";
    hit_alarm();
    chk({31'h0, pwr_en}, 32'h0, "R5 shutdown on match");
    rd_chk(8'h44, 32'h80, "R3 flag set on match");
    chk({31'h0, irq}, 32'h1, "R10 irq with enable");

    cur_tag = "R7";
    wake_pins = 4'b0000; tick(5);
    chk({31'h0, pwr_en}, 32'h0, "R7 disabled pins ignored");
    wake_pins = 4'b1111; tick(3);
    wr(8'h98, 32'h0001_0044);
    tick(3);
    chk({31'h0, pwr_en}, 32'h0, "R7 inactive level ignored");
    wake_pins = 4'b1011; tick(2);
    chk({31'h0, pwr_en}, 32'h0, "R7 still off after two edges");
    tick(1);
    chk({31'h0, pwr_en}, 32'h1, "R7 restored on third edge");
    wake_pins = 4'b1111; tick(3);

    cur_tag = "R9";
    rd_chk(8'h44, 32'h80, "R9 flag kept after restore");
    hit_alarm();
    chk({31'h0, pwr_en}, 32'h1, "R9 match with flag set ignored");

    cur_tag = "R4";
    wr(8'h44, 32'h0);
    rd_chk(8'h44, 32'h80, "R4 write zero keeps flag");
    wr(8'h44, 32'h80);
    rd_chk(8'h44, 32'h0, "R4 write one clears flag");

    cur_tag = "R9";
    hit_alarm();
    chk({31'h0, pwr_en}, 32'h0, "R9 rearmed shutdown");

    cur_tag = "R8";
    wr(8'h48, 32'h10);
    main_alarm = 1'b1; tick(2);
    chk({31'h0, pwr_en}, 32'h0, "R8 main alarm without enable");
    main_alarm = 1'b0;
    wr(8'h48, 32'h18);
    main_alarm = 1'b1; tick(1);
    main_alarm = 1'b0;
    chk({31'h0, pwr_en}, 32'h1, "R8 main alarm restores power");

    cur_tag = "R6";
    wr(8'h44, 32'h80);
    wr(8'h98, 32'h0);
    hit_alarm();
    chk({31'h0, pwr_en}, 32'h1, "R6 control off keeps power");
    chk({31'h0, irq}, 32'h1, "R10 irq follows flag");
    wr(8'h44, 32'h80);
    chk({31'h0, irq}, 32'h0, "R10 irq drops with flag");
    wr(8'h98, 32'h0001_0000);
    hit_alarm();
    chk({31'h0, pwr_en}, 32'h0, "R6 control on shuts down");
    wr(8'h98, 32'h0);
    chk({31'h0, pwr_en}, 32'h1, "R6 clearing control restores");

    cur_tag = "R11";
    wr(8'h44, 32'h80);
    wr(8'h98, 32'h0001_0001);
    tick(2);
    chk({31'h0, pwr_en}, 32'h1, "R11 setup powered");
    hit_alarm();
    chk({31'h0, pwr_en}, 32'h0, "R11 shutdown wins");
    tick(1);
    chk({31'h0, pwr_en}, 32'h1, "R11 wake follows");

    cur_tag = "R4";
    wr(8'h98, 32'h0);
    now_bcd = AWAY; tick(1);
    now_bcd = ALM;
    wr(8'h44, 32'h80);
    rd_chk(8'h44, 32'h80, "R4 match wins over clear");

    cur_tag = "R3";
    wr(8'h44, 32'h80);
    tick(3);
    rd_chk(8'h44, 32'h0, "R3 steady equality does not re-fire");

    tick(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule